// File: doc/BRIEF.md
# Three-Slot 16K Cartridge Bank Mapper

This block sits between a CPU's 64K address space and a banked cartridge. The space is divided into four 16K slots. The lower three slots read cartridge ROM through bank registers. The top slot holds internal work RAM. Each bank register is loaded by a CPU write to the first byte of the slot it controls. Such a write is consumed by the mapper and never reaches memory. For every CPU address, the block decides combinationally whether it is a ROM read, a cartridge-RAM access or a work-RAM access. It also produces the physical address for that target.

Bit 7 of the value written to the middle slot's register opens an 8K cartridge-RAM window in the upper half of the third slot. While the window is open, the lower half of that slot still follows its ROM bank. Each written value is reduced modulo the number of 16K pages in the ROM, so a value larger than the ROM wraps. A sticky flag records that cartridge RAM has been switched in, so that contents needing to be kept can be recognised.

Top module: `cart_bank_mapper`

## Requirements
- R1: A CPU write to address 0x0000 loads the bank for 0x0000–0x3FFF. Writes to any other address in that slot change no bank.
- R2: A CPU write to address 0x4000 loads the bank for 0x4000–0x7FFF.
- R3: A CPU write to address 0x8000 loads the bank for 0x8000–0xBFFF. While the window is closed, both halves of that slot read ROM through this bank.
- R4: A register write at 0x0000, 0x4000 or 0x8000 never asserts mem_we.
- R5: Every ROM read in 0x0000–0x3FFF has rom_addr = bank×16384 + addr[13:0], including the first 1K. No page is fixed.
- R6: A write to 0x4000 with data bit 7 set opens the window. While open, 0xA000–0xBFFF selects cartridge RAM (cram_en=1, rom_en=0) with ram_addr = addr[12:0], and CPU writes there assert mem_we. A write to 0x4000 with bit 7 clear closes the window, and 0xA000–0xBFFF again reads ROM through the latest slot-2 bank.
- R7: While the window is open, 0x8000–0x9FFF still reads ROM, and a write to 0x8000 still changes its bank.
- R8: The bank loaded by a register write is the written byte modulo PAGES.
- R9: After reset the three banks are 0, 1 mod PAGES and 0, the window is closed and save_flag is 0.
- R10: 0xC000–0xFFFF selects work RAM (wram_en=1) with ram_addr = addr[12:0], so each 8K half mirrors the other. Writes there assert mem_we. Writes to ROM-mapped addresses never assert mem_we. Exactly one of rom_en, cram_en and wram_en is high for every address.
- R11: save_flag rises on the cycle after the window is opened and stays high until reset, even after the window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe for the current address |
| cpu_wdata | input | 8 | CPU write data |
| rom_addr | output | PW+14 | Physical ROM byte address |
| rom_en | output | 1 | Address maps to cartridge ROM |
| cram_en | output | 1 | Address maps to cartridge RAM window |
| wram_en | output | 1 | Address maps to work RAM |
| ram_addr | output | 13 | Offset into cartridge or work RAM |
| mem_we | output | 1 | CPU write reaches the selected RAM |
| save_flag | output | 1 | Cartridge RAM has been switched in since reset |

## Verification
Each bank register is swept through all 256 data values with a six-page ROM, so wrap-around is exercised at a non-power-of-two size. Probes at the first byte, the end of the first 1K and the last byte of each slot separate a correct full-slot bank from a fixed first page or a wrong offset. The slot-2 sweep runs once with the window closed and once with it open. This tells apart a correct window priority from one that lets the bank register override the RAM, or that stops updating the lower half. Writes to non-register ROM addresses, to the RAM window and to both work-RAM mirrors show which accesses are swallowed and which reach memory.

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int PAGES = 8,
  localparam int PW = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [15:0]    cpu_addr,
  input  logic           cpu_wr,
  input  logic [7:0]     cpu_wdata,
  output logic [PW+13:0] rom_addr,
  output logic           rom_en,
  output logic           cram_en,
  output logic           wram_en,
  output logic [12:0]    ram_addr,
  output logic           mem_we,
  output logic           save_flag
);
  localparam logic [PW-1:0] BANK1_INIT = PW'(1 % PAGES);

  logic [PW-1:0] bank0, bank1, bank2, page;
  logic          win;

  wire [PW-1:0] wpage = PW'(32'(cpu_wdata) % PAGES);
  wire reg_hit = cpu_wr && (cpu_addr[13:0] == 14'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank0     <= '0;
      bank1     <= BANK1_INIT;
      bank2     <= '0;
      win       <= 1'b0;
      save_flag <= 1'b0;
    end else if (reg_hit) begin
      case (cpu_addr[15:14])
        2'd0: bank0 <= wpage;
        2'd1: begin
          bank1 <= wpage;
          win   <= cpu_wdata[7];
          if (cpu_wdata[7]) save_flag <= 1'b1;
        end
        2'd2: bank2 <= wpage;
        default: ;
      endcase
    end
  end

  always_comb begin
    rom_en  = 1'b0;
    cram_en = 1'b0;
    wram_en = 1'b0;
    page    = bank0;
    case (cpu_addr[15:14])
      2'd0: rom_en = 1'b1;
      2'd1: begin rom_en = 1'b1; page = bank1; end
      2'd2: begin
        page = bank2;
        if (win && cpu_addr[13]) cram_en = 1'b1;
        else rom_en = 1'b1;
      end
      default: wram_en = 1'b1;
    endcase
  end

  assign rom_addr = {page, cpu_addr[13:0]};
  assign ram_addr = cpu_addr[12:0];
  assign mem_we   = cpu_wr && (cram_en || wram_en);
endmodule

module cart_bank_mapper_chk #(
  parameter int PAGES = 8,
  localparam int PW = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [15:0]    cpu_addr,
  input logic           cpu_wr,
  input logic [7:0]     cpu_wdata,
  input logic [PW+13:0] rom_addr,
  input logic           rom_en,
  input logic           cram_en,
  input logic           wram_en,
  input logic [12:0]    ram_addr,
  input logic           mem_we,
  input logic           save_flag
);
  p_swallow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && (cpu_addr == 16'h0000 || cpu_addr == 16'h4000 || cpu_addr == 16'h8000)) |-> !mem_we);

  p_slot0_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h0000) |=>
      (cpu_addr[15:14] != 2'd0 || rom_addr[PW+13:14] == PW'(32'($past(cpu_wdata)) % PAGES)));

  p_slot1_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h4000) |=>
      (cpu_addr[15:14] != 2'd1 || rom_addr[PW+13:14] == PW'(32'($past(cpu_wdata)) % PAGES)));

  p_slot2_lo_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h8000) |=>
      (cpu_addr[15:13] != 3'b100 || (rom_en && rom_addr[PW+13:14] == PW'(32'($past(cpu_wdata)) % PAGES))));

  p_window_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h4000 && cpu_wdata[7]) |=>
      (cpu_addr[15:13] != 3'b101 || (cram_en && !rom_en && ram_addr == cpu_addr[12:0])));

  p_wram_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'd3) |-> (wram_en && ram_addr == cpu_addr[12:0] && mem_we == cpu_wr));

  p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({rom_en, cram_en, wram_en}));

  p_save_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    save_flag |=> save_flag);

  p_save_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(save_flag) |-> $past(cpu_wr && cpu_addr == 16'h4000 && cpu_wdata[7]));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.PAGES(PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .rom_addr(rom_addr), .rom_en(rom_en), .cram_en(cram_en), .wram_en(wram_en),
  .ram_addr(ram_addr), .mem_we(mem_we), .save_flag(save_flag)
);

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  localparam int PAGES = 6;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   cpu_addr = '0;
  logic          cpu_wr = 1'b0;
  logic [7:0]    cpu_wdata = '0;
  logic [PW+13:0] rom_addr;
  logic          rom_en, cram_en, wram_en, mem_we, save_flag;
  logic [12:0]   ram_addr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_b0, m_b1, m_b2;
  bit m_win, m_save;

  always #2 clk = ~clk;

  cart_bank_mapper #(.PAGES(PAGES)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .rom_addr(rom_addr), .rom_en(rom_en), .cram_en(cram_en), .wram_en(wram_en),
    .ram_addr(ram_addr), .mem_we(mem_we), .save_flag(save_flag)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_b0 = 0; m_b1 = 1 % PAGES; m_b2 = 0; m_win = 0; m_save = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_wr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic wr(input string req, input logic [15:0] a, input logic [7:0] d);
    bit is_reg, reaches;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    is_reg  = (a == 16'h0000) || (a == 16'h4000) || (a == 16'h8000);
    reaches = (a[15:14] == 2'd3) || (a[15:13] == 3'b101 && m_win);
    check(req, "mem_we", longint'(mem_we), longint'(reaches && !is_reg));
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a == 16'h0000) m_b0 = d % PAGES;
    if (a == 16'h4000) begin
      m_b1 = d % PAGES; m_win = d[7];
      if (d[7]) m_save = 1;
    end
    if (a == 16'h8000) m_b2 = d % PAGES;
  endtask

  task automatic probe(input string req, input logic [15:0] a);
    int pg;
    logic [2:0] sel;
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0;
    #1;
    if (a[15:14] == 2'd3) sel = 3'b001;
    else if (a[15:13] == 3'b101 && m_win) sel = 3'b010;
    else sel = 3'b100;
    check(req, "select", longint'({rom_en, cram_en, wram_en}), longint'(sel));
    if (sel == 3'b100) begin
      pg = (a[15:14] == 2'd0) ? m_b0 : (a[15:14] == 2'd1) ? m_b1 : m_b2;
      check(req, "rom_addr", longint'(rom_addr), longint'(pg) * 16384 + longint'(a[13:0]));
    end else begin
      check(req, "ram_addr", longint'(ram_addr), longint'(a[12:0]));
    end
    check(req, "save_flag", longint'(save_flag), longint'(m_save));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R9: reset state
    probe("R9", 16'h0000);
    probe("R9", 16'h4000);
    probe("R9", 16'h8000);
    probe("R9", 16'hA000);
    check("R9", "save_flag", longint'(save_flag), 0);

    // R1 R5 R8: slot-0 sweep
    for (int d = 0; d < 256; d++) begin
      wr("R4", 16'h0000, 8'(d));
      probe("R1", 16'h0000);
      probe("R5", 16'h03FF);
      probe("R8", 16'h3FFF);
    end
    // R1: non-register address in slot 0 changes nothing
    wr("R10", 16'h0001, 8'h03);
    probe("R1", 16'h0000);
    wr("R10", 16'h1234, 8'h05);
    probe("R1", 16'h2000);

    // R2 R8: slot-1 sweep, bit-7 values clear-and-reopen the window
    for (int d = 0; d < 256; d++) begin
      wr("R4", 16'h4000, 8'(d));
      probe("R2", 16'h4000);
      probe("R8", 16'h7FFF);
    end
    do_reset();
    probe("R9", 16'h4000);

    // R3: slot-2 sweep, window closed
    for (int d = 0; d < 256; d++) begin
      wr("R4", 16'h8000, 8'(d));
      probe("R3", 16'h8000);
      probe("R3", 16'hA000);
      probe("R3", 16'hBFFF);
    end

    // R6 R11: open window
    wr("R6", 16'h4000, 8'h83);
    probe("R6", 16'hA000);
    probe("R6", 16'hBFFF);
    probe("R11", 16'h4000);
    wr("R6", 16'hA123, 8'h55);
    wr("R6", 16'hBFFE, 8'hAA);

    // R7: slot-2 sweep with window open
    for (int d = 0; d < 256; d++) begin
      wr("R7", 16'h8000, 8'(d));
      probe("R7", 16'h8000);
      probe("R7", 16'h9FFF);
      probe("R6", 16'hA000);
    end
    wr("R7", 16'h8000, 8'h04);

    // R6 R11: close window, upper half back to latest slot-2 bank, flag stays
    wr("R6", 16'h4000, 8'h02);
    probe("R6", 16'hA000);
    probe("R6", 16'hBFFF);
    probe("R11", 16'hA000);
    wr("R10", 16'hA000, 8'h11);

    // R10: work RAM mirror and write enable
    probe("R10", 16'hC000);
    probe("R10", 16'hE000);
    probe("R10", 16'hFFFF);
    wr("R10", 16'hD000, 8'h77);
    wr("R10", 16'hFFFF, 8'h01);
    wr("R10", 16'h5555, 8'h01);
    probe("R10", 16'h5555);

    // R9: reset clears flag and window
    do_reset();
    probe("R9", 16'hA000);
    probe("R9", 16'h4000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule